// File: doc/BRIEF.md
# Banked Nibble Register File

This block is the general-purpose register storage of a 4-bit processor core. It has four banks, and each bank holds eight 4-bit registers named B, C, D, E, H, L, X and A. A bank-select value and an enable flag are loaded through their own strobe. Together they pick the bank that register operands use. When the flag is clear, operands always come from bank 0.

The register port serves the instruction datapath. It reads or writes one register as a nibble, or one of the pairs BC, DE, HL and XA as a byte. A pair access can also target the alternate bank, which is the active bank number with its least significant bit flipped.

A second port, the memory port, sees the same 32 nibbles as plain data memory at addresses 00H to 1FH. Through it, software can use the register area as RAM whether or not those registers are in use. Reads on both ports are combinational. Writes take effect on the rising clock edge.

Top module: `nib_regfile`

## Requirements
- R1: The memory port maps bank b, register offset o to address 8*b+o (addresses 00H..1FH). mp_rdata shows the addressed nibble combinationally. A write with mp_we stores mp_wdata at the rising edge.
- R2: The active bank equals the loaded select value ANDed bitwise with the loaded enable flag. With the enable flag at 0, bank 0 is active whatever the select value.
- R3: bank_sel_in and bank_en_in are captured only on a rising edge where bank_wr is 1. cur_bank keeps its old value until that edge and shows the new bank from the following cycle on.
- R4: A synchronous reset sets cur_bank to 0 and leaves every stored nibble unchanged.
- R5: Register codes on rp_idx are B=0, C=1, D=2, E=3, H=4, L=5, X=6, A=7. A single access (rp_wide=0) uses offset code XOR 1. It returns the nibble in rp_rdata[3:0] with rp_rdata[7:4]=0, and a write stores only rp_wdata[3:0].
- R6: A pair access (rp_wide=1) selects pair rp_idx[2:1] (0=BC, 1=DE, 2=HL, 3=XA) and ignores rp_idx[0]. The low byte half [3:0] is the even offset (C, E, L, A) and the high half [7:4] is the odd offset (B, D, H, X). Both nibbles are read or written together.
- R7: A pair access with rp_alt=1 uses the bank numbered active bank XOR 1. A single access ignores rp_alt.
- R8: When both ports write the same nibble in one cycle, the register-port data is stored. Writes to different nibbles in the same cycle both take effect.
- R9: Both ports share one storage. A value written through either port is read back through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the bank state |
| bank_wr | input | 1 | Load strobe for bank select and enable |
| bank_sel_in | input | 2 | Bank select value to load |
| bank_en_in | input | 1 | Bank enable flag to load |
| cur_bank | output | 2 | Active bank number |
| rp_we | input | 1 | Register-port write enable |
| rp_wide | input | 1 | 1 = pair (byte) access, 0 = single nibble |
| rp_alt | input | 1 | Pair access targets the alternate bank |
| rp_idx | input | 3 | Register code (pair in bits 2:1 when wide) |
| rp_wdata | input | 8 | Register-port write data |
| rp_rdata | output | 8 | Register-port read data |
| mp_we | input | 1 | Memory-port write enable |
| mp_addr | input | 5 | Memory-port nibble address |
| mp_wdata | input | 4 | Memory-port write data |
| mp_rdata | output | 4 | Memory-port read data |

## Verification
The assertions assume that every control input is a known 0 or 1 on each clock edge once reset is released. They also assume that rst is asserted from time zero, so the bank state starts defined. Stored nibbles have no reset, so the bench writes all 32 addresses through the memory port before it reads anything. It drives every input on the falling edge and holds rp_we and mp_we low except in the cycles of an intended write.

// File: rtl/nrf_pkg.sv
package nrf_pkg;

  localparam int REG_IDX_W = 3;
  localparam int REGS_PER_BANK = 1 << REG_IDX_W;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_B = 3'd0,
    REG_C = 3'd1,
    REG_D = 3'd2,
    REG_E = 3'd3,
    REG_H = 3'd4,
    REG_L = 3'd5,
    REG_X = 3'd6,
    REG_A = 3'd7
  } reg_code_e;

  // Single register: the second letter of each pair sits at the even slot.
  function automatic logic [REG_IDX_W-1:0] single_offset(logic [REG_IDX_W-1:0] code);
    return code ^ 3'b001;
  endfunction

  // Pair: even-aligned slot of the low nibble.
  function automatic logic [REG_IDX_W-1:0] pair_offset(logic [REG_IDX_W-1:0] code);
    return {code[REG_IDX_W-1:1], 1'b0};
  endfunction

endpackage

// File: rtl/nrf_bank_ctl.sv
module nrf_bank_ctl #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BANK_W-1:0] sel_in,
  input  logic              en_in,
  output logic [BANK_W-1:0] act_bank
);

  logic [BANK_W-1:0] sel_q;
  logic              en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      en_q  <= 1'b0;
    end else if (load) begin
      sel_q <= sel_in;
      en_q  <= en_in;
    end
  end

  assign act_bank = sel_q & {BANK_W{en_q}};

endmodule

// File: rtl/nrf_port_map.sv
module nrf_port_map #(
  parameter int BANK_W = 2,
  parameter int ADDR_W = BANK_W + nrf_pkg::REG_IDX_W
) (
  input  logic [BANK_W-1:0]             act_bank,
  input  logic                          wide,
  input  logic                          alt,
  input  logic [nrf_pkg::REG_IDX_W-1:0] idx,
  output logic [BANK_W-1:0]             tgt_bank,
  output logic [ADDR_W-1:0]             addr_lo,
  output logic [ADDR_W-1:0]             addr_hi
);

  import nrf_pkg::*;

  logic [REG_IDX_W-1:0] off_lo;

  always_comb begin
    tgt_bank = act_bank;
    if (wide && alt) tgt_bank = act_bank ^ BANK_W'(1);
    off_lo = wide ? pair_offset(idx) : single_offset(idx);
  end

  assign addr_lo = {tgt_bank, off_lo};
  assign addr_hi = {tgt_bank, off_lo | REG_IDX_W'(1)};

endmodule

// File: rtl/nrf_store.sv
module nrf_store #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 5,
  parameter int NIB_W  = 4
) (
  input  logic               clk,
  input  logic               rp_we,
  input  logic               rp_wide,
  input  logic [ADDR_W-1:0]  rp_addr_lo,
  input  logic [ADDR_W-1:0]  rp_addr_hi,
  input  logic [2*NIB_W-1:0] rp_wdata,
  input  logic               mp_we,
  input  logic [ADDR_W-1:0]  mp_addr,
  input  logic [NIB_W-1:0]   mp_wdata,
  output logic [NIB_W-1:0]   rp_rd_lo,
  output logic [NIB_W-1:0]   rp_rd_hi,
  output logic [NIB_W-1:0]   mp_rdata,
  output logic [DEPTH-1:0]   rp_mask,
  output logic [DEPTH-1:0]   mp_mask,
  output logic [DEPTH-1:0]   hi_sel
);

  logic [NIB_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    logic hit_lo, hit_hi;
    assign hit_lo     = (rp_addr_lo == ADDR_W'(i));
    assign hit_hi     = rp_wide && (rp_addr_hi == ADDR_W'(i));
    assign hi_sel[i]  = hit_hi;
    assign rp_mask[i] = rp_we && (hit_lo || hit_hi);
    assign mp_mask[i] = mp_we && (mp_addr == ADDR_W'(i)) && !rp_mask[i];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rp_mask[i])
        mem[i] <= hi_sel[i] ? rp_wdata[2*NIB_W-1:NIB_W] : rp_wdata[NIB_W-1:0];
      else if (mp_mask[i])
        mem[i] <= mp_wdata;
    end
  end

  assign rp_rd_lo = mem[rp_addr_lo];
  assign rp_rd_hi = mem[rp_addr_hi];
  assign mp_rdata = mem[mp_addr];

endmodule

// File: rtl/nib_regfile.sv
module nib_regfile #(
  parameter int NUM_BANKS = 4,
  parameter int NIB_W     = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int ADDR_W    = BANK_W + nrf_pkg::REG_IDX_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bank_wr,
  input  logic [BANK_W-1:0]             bank_sel_in,
  input  logic                          bank_en_in,
  output logic [BANK_W-1:0]             cur_bank,
  input  logic                          rp_we,
  input  logic                          rp_wide,
  input  logic                          rp_alt,
  input  logic [nrf_pkg::REG_IDX_W-1:0] rp_idx,
  input  logic [2*NIB_W-1:0]            rp_wdata,
  output logic [2*NIB_W-1:0]            rp_rdata,
  input  logic                          mp_we,
  input  logic [ADDR_W-1:0]             mp_addr,
  input  logic [NIB_W-1:0]              mp_wdata,
  output logic [NIB_W-1:0]              mp_rdata
);

  localparam int DEPTH = NUM_BANKS * nrf_pkg::REGS_PER_BANK;

  logic [BANK_W-1:0] tgt_bank;
  logic [ADDR_W-1:0] rp_addr_lo, rp_addr_hi;
  logic [NIB_W-1:0]  rp_rd_lo, rp_rd_hi;
  logic [DEPTH-1:0]  rp_mask, mp_mask, hi_sel;

  nrf_bank_ctl #(.BANK_W(BANK_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .load     (bank_wr),
    .sel_in   (bank_sel_in),
    .en_in    (bank_en_in),
    .act_bank (cur_bank)
  );

  nrf_port_map #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_map (
    .act_bank (cur_bank),
    .wide     (rp_wide),
    .alt      (rp_alt),
    .idx      (rp_idx),
    .tgt_bank (tgt_bank),
    .addr_lo  (rp_addr_lo),
    .addr_hi  (rp_addr_hi)
  );

  nrf_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_store (
    .clk        (clk),
    .rp_we      (rp_we),
    .rp_wide    (rp_wide),
    .rp_addr_lo (rp_addr_lo),
    .rp_addr_hi (rp_addr_hi),
    .rp_wdata   (rp_wdata),
    .mp_we      (mp_we),
    .mp_addr    (mp_addr),
    .mp_wdata   (mp_wdata),
    .rp_rd_lo   (rp_rd_lo),
    .rp_rd_hi   (rp_rd_hi),
    .mp_rdata   (mp_rdata),
    .rp_mask    (rp_mask),
    .mp_mask    (mp_mask),
    .hi_sel     (hi_sel)
  );

  assign rp_rdata = rp_wide ? {rp_rd_hi, rp_rd_lo} : {{NIB_W{1'b0}}, rp_rd_lo};

endmodule

// File: rtl/nrf_checker.sv
module nrf_checker #(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bank_wr,
  input logic [BANK_W-1:0] bank_sel_in,
  input logic              bank_en_in,
  input logic [BANK_W-1:0] cur_bank,
  input logic              rp_we,
  input logic              rp_wide,
  input logic              rp_alt,
  input logic              mp_we,
  input logic [ADDR_W-1:0] mp_addr,
  input logic [BANK_W-1:0] tgt_bank,
  input logic [ADDR_W-1:0] rp_addr_lo,
  input logic [DEPTH-1:0]  rp_mask,
  input logic [DEPTH-1:0]  mp_mask
);

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
    bank_wr |=> cur_bank == ($past(bank_en_in) ? $past(bank_sel_in) : '0)); // R3

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bank_wr |=> $stable(cur_bank)); // R3

  AST_GATED_BANK: assert property (@(posedge clk) disable iff (rst)
    (bank_wr && !bank_en_in) |=> cur_bank == '0); // R2

  AST_ALT_TARGET: assert property (@(posedge clk) disable iff (rst)
    (rp_wide && rp_alt) |-> tgt_bank == (cur_bank ^ BANK_W'(1))); // R7

  AST_NARROW_TARGET: assert property (@(posedge clk) disable iff (rst)
    !rp_wide |-> tgt_bank == cur_bank); // R7

  AST_SINGLE_ONE: assert property (@(posedge clk) disable iff (rst)
    (rp_we && !rp_wide) |-> $countones(rp_mask) == 1); // R5

  AST_PAIR_TWO: assert property (@(posedge clk) disable iff (rst)
    (rp_we && rp_wide) |-> ($countones(rp_mask) == 2 && !rp_addr_lo[0])); // R6

  AST_REG_WINS: assert property (@(posedge clk) disable iff (rst)
    (mp_we && rp_mask[mp_addr]) |-> mp_mask == '0); // R8

  AST_MEM_ONE: assert property (@(posedge clk) disable iff (rst)
    (mp_we && !rp_mask[mp_addr]) |-> $countones(mp_mask) == 1); // R1

endmodule

bind nib_regfile nrf_checker #(.BANK_W(BANK_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bank_wr     (bank_wr),
  .bank_sel_in (bank_sel_in),
  .bank_en_in  (bank_en_in),
  .cur_bank    (cur_bank),
  .rp_we       (rp_we),
  .rp_wide     (rp_wide),
  .rp_alt      (rp_alt),
  .mp_we       (mp_we),
  .mp_addr     (mp_addr),
  .tgt_bank    (tgt_bank),
  .rp_addr_lo  (rp_addr_lo),
  .rp_mask     (rp_mask),
  .mp_mask     (mp_mask)
);

// File: tb/sim_nib_regfile.sv
module sim_nib_regfile;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bank_wr = 1'b0;
  logic [1:0] bank_sel_in = '0;
  logic       bank_en_in = 1'b0;
  logic [1:0] cur_bank;
  logic       rp_we = 1'b0;
  logic       rp_wide = 1'b0;
  logic       rp_alt = 1'b0;
  logic [2:0] rp_idx = '0;
  logic [7:0] rp_wdata = '0;
  logic [7:0] rp_rdata;
  logic       mp_we = 1'b0;
  logic [4:0] mp_addr = '0;
  logic [3:0] mp_wdata = '0;
  logic [3:0] mp_rdata;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  nib_regfile u0 (
    .clk(clk), .rst(rst), .bank_wr(bank_wr), .bank_sel_in(bank_sel_in),
    .bank_en_in(bank_en_in), .cur_bank(cur_bank), .rp_we(rp_we),
    .rp_wide(rp_wide), .rp_alt(rp_alt), .rp_idx(rp_idx), .rp_wdata(rp_wdata),
    .rp_rdata(rp_rdata), .mp_we(mp_we), .mp_addr(mp_addr),
    .mp_wdata(mp_wdata), .mp_rdata(mp_rdata)
  );

  // Fill pattern written through the memory port: (5*a + 3) mod 16.
  function automatic logic [3:0] pat(int a);
    return 4'((a * 5 + 3) % 16);
  endfunction

  // Entry: {en, sel[1:0], wide, alt, idx[2:0], expected rp_rdata[7:0]}
  localparam logic [15:0] VEC [12] = '{
    {1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 8'h08},  // R2: enable off, B of bank 0
    {1'b1, 2'd2, 1'b0, 1'b0, 3'd7, 8'h01},  // R5: A of bank 2
    {1'b1, 2'd1, 1'b0, 1'b0, 3'd4, 8'h04},  // R5: H of bank 1
    {1'b1, 2'd1, 1'b1, 1'b0, 3'd2, 8'hA5},  // R6: DE of bank 1
    {1'b1, 2'd1, 1'b1, 1'b1, 3'd2, 8'h2D},  // R7: DE' -> bank 0
    {1'b1, 2'd2, 1'b1, 1'b1, 3'd6, 8'hE9},  // R7: XA' -> bank 3
    {1'b1, 2'd3, 1'b1, 1'b0, 3'd7, 8'hE9},  // R6: idx bit 0 ignored
    {1'b1, 2'd3, 1'b1, 1'b1, 3'd1, 8'h83},  // R7: BC' -> bank 2
    {1'b0, 2'd2, 1'b1, 1'b1, 3'd4, 8'h4F},  // R2: gated 0, HL' -> bank 1
    {1'b1, 2'd2, 1'b0, 1'b1, 3'd3, 8'h0D},  // R7: alt ignored on single
    {1'b1, 2'd0, 1'b0, 1'b0, 3'd5, 8'h07},  // R5: L of bank 0
    {1'b1, 2'd3, 1'b0, 1'b0, 3'd6, 8'h0E}   // R5: X of bank 3
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_bank(logic en, logic [1:0] sel);
    @(negedge clk);
    bank_wr = 1'b1; bank_en_in = en; bank_sel_in = sel;
    @(negedge clk);
    bank_wr = 1'b0;
  endtask

  task automatic rp_write(logic wide, logic alt, logic [2:0] idx, logic [7:0] d);
    @(negedge clk);
    rp_we = 1'b1; rp_wide = wide; rp_alt = alt; rp_idx = idx; rp_wdata = d;
    @(negedge clk);
    rp_we = 1'b0; rp_alt = 1'b0; rp_wide = 1'b0;
  endtask

  task automatic mem_peek(logic [4:0] a, logic [3:0] exp, string tag);
    mp_addr = a;
    #1;
    check(tag, {4'h0, mp_rdata}, {4'h0, exp});
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R4 reset bank", {6'h0, cur_bank}, 8'h00);

    // R1: fill whole area through the memory port, then read back
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      mp_we = 1'b1; mp_addr = 5'(a); mp_wdata = pat(a);
    end
    @(negedge clk);
    mp_we = 1'b0;
    for (int a = 0; a < 32; a++) mem_peek(5'(a), pat(a), "R1 fill readback");

    // Table walk: bank setup then register-port read
    for (int k = 0; k < 12; k++) begin
      set_bank(VEC[k][15], VEC[k][14:13]);
      check("R2 active bank", {6'h0, cur_bank},
            {6'h0, VEC[k][14:13] & {2{VEC[k][15]}}});
      rp_wide = VEC[k][12]; rp_alt = VEC[k][11]; rp_idx = VEC[k][10:8];
      #1;
      check("R5/R6/R7 table read", rp_rdata, VEC[k][7:0]);
      rp_wide = 1'b0; rp_alt = 1'b0;
    end

    // R3: new bank only after the loading edge
    set_bank(1'b1, 2'd1);
    @(negedge clk);
    bank_wr = 1'b1; bank_en_in = 1'b1; bank_sel_in = 2'd2;
    #1;
    check("R3 before edge", {6'h0, cur_bank}, 8'h01);
    @(posedge clk);
    #1;
    check("R3 after edge", {6'h0, cur_bank}, 8'h02);
    @(negedge clk);
    bank_wr = 1'b0;

    // R5: single write to C of bank 1 stores the low nibble only
    set_bank(1'b1, 2'd1);
    rp_write(1'b0, 1'b0, 3'd1, 8'hF6);
    mem_peek(5'd8, 4'h6, "R5 single write");
    mem_peek(5'd9, pat(9), "R5 neighbour untouched");
    rp_idx = 3'd1;
    #1;
    check("R5 single read upper zero", rp_rdata, 8'h06);

    // R6/R7: pair write to HL' with bank 2 active lands in bank 3
    set_bank(1'b1, 2'd2);
    rp_write(1'b1, 1'b1, 3'd5, 8'h3C);
    mem_peek(5'd28, 4'hC, "R6 pair low nibble");
    mem_peek(5'd29, 4'h3, "R7 pair high in alt bank");
    mem_peek(5'd20, pat(20), "R7 active bank untouched");

    // R9: memory-port write seen by the register port (X of bank 1)
    set_bank(1'b1, 2'd1);
    @(negedge clk);
    mp_we = 1'b1; mp_addr = 5'd15; mp_wdata = 4'h7;
    @(negedge clk);
    mp_we = 1'b0;
    rp_idx = 3'd6; rp_wide = 1'b0;
    #1;
    check("R9 shared storage", rp_rdata, 8'h07);

    // R8: collisions in bank 0
    set_bank(1'b0, 2'd0);
    @(negedge clk);
    rp_we = 1'b1; rp_wide = 1'b0; rp_idx = 3'd7; rp_wdata = 8'h05;
    mp_we = 1'b1; mp_addr = 5'd6; mp_wdata = 4'h9;
    @(negedge clk);
    rp_we = 1'b0; mp_we = 1'b0;
    mem_peek(5'd6, 4'h5, "R8 single collision");

    @(negedge clk);
    rp_we = 1'b1; rp_wide = 1'b1; rp_idx = 3'd0; rp_wdata = 8'h21;
    mp_we = 1'b1; mp_addr = 5'd1; mp_wdata = 4'hF;
    @(negedge clk);
    rp_we = 1'b0; mp_we = 1'b0; rp_wide = 1'b0;
    mem_peek(5'd1, 4'h2, "R8 pair collision");
    mem_peek(5'd0, 4'h1, "R8 pair low");

    @(negedge clk);
    rp_we = 1'b1; rp_idx = 3'd3; rp_wdata = 8'h04;
    mp_we = 1'b1; mp_addr = 5'd3; mp_wdata = 4'hA;
    @(negedge clk);
    rp_we = 1'b0; mp_we = 1'b0;
    mem_peek(5'd2, 4'h4, "R8 disjoint reg write");
    mem_peek(5'd3, 4'hA, "R8 disjoint mem write");

    // R4: reset clears the bank, keeps contents
    set_bank(1'b1, 2'd3);
    check("R3 bank loaded", {6'h0, cur_bank}, 8'h03);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R4 bank cleared", {6'h0, cur_bank}, 8'h00);
    mem_peek(5'd31, pat(31), "R4 contents kept");
    mem_peek(5'd28, 4'hC, "R4 contents kept");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule